// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block sits after the pixel digitizer of a display input path. It receives one parallel RGB word per pixel clock, qualified by a valid strobe, together with a horizontal sync reference. It then presents the stream on one or two output ports. In single-port mode every pixel goes to port A and port B is switched off. In dual-port mode the stream is split into A/B pairs, so each port carries half the pixel rate. The alternation is always re-aligned so that the pixel at a horizontal sync leading edge lands on port A.

The block also produces a forwarded data clock that a downstream receiver uses to latch the ports. Its rising edge is placed midway between changes of the port data. The port mode is chosen by a request input that is sampled only at a sync leading edge, so a line is never split across two alignments. Every update reaches the ports after a fixed pipeline delay.

Top module: `pix_demux`

## Requirements
- R1: In dual-port mode, the valid pixel at a sync leading edge always becomes the port A half of a pair. A leading edge is a valid cycle with `hsync`=1 where `hsync` was 0 on the previous valid cycle. Cycles with `pix_valid`=0 do not update the sync history.
- R2: In dual-port mode, the valid pixels after the A pixel alternate B, A, B, and so on. When the B pixel arrives, `port_a` and `port_b` both update on the same edge, and the pair then stays unchanged for at least two clocks.
- R3: In single-port mode, every valid pixel is written to `port_a`. `port_b_oe` is 0 (port B is high impedance) and `port_b` does not change.
- R4: When `port_b_oe`=1, `data_clk` is 0 for the clock after a pair update and 1 for the clock that follows, so it rises one pixel period after the data changes. When `port_b_oe`=0, `data_clk` is the inverted pixel clock, so it rises halfway between `port_a` transitions.
- R5: A port update appears on the outputs at the 7th rising edge counting the edge that samples the pixel that completes it (`LATENCY`=7). That pixel is the pixel itself in single-port mode and the B pixel in dual-port mode. `port_b_oe` follows the active mode with the same delay.
- R6: If a leading edge arrives while a B pixel is expected, the waiting A pixel is discarded without reaching the ports. The leading-edge pixel starts a new pair as A.
- R7: `dual_req` (1 = dual-port, 0 = single-port) is sampled only on a leading-edge pixel. It is ignored on every other cycle.
- R8: A cycle with `pix_valid`=0 takes no A/B slot and leaves both ports unchanged.
- R9: A synchronous active-high `rst` clears `port_a`, `port_b` and the pipeline to zero, sets `port_b_oe` to 0, selects single-port mode and sets the next slot to A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel word on `pix_data` is valid this cycle |
| pix_data | input | PIX_W | Digitized RGB pixel word |
| hsync | input | 1 | Horizontal sync reference, active high |
| dual_req | input | 1 | Requested port mode, taken at a sync leading edge |
| port_a | output | PIX_W | Port A data (every pixel, or the even half of a pair) |
| port_b | output | PIX_W | Port B data (odd half of a pair) |
| port_b_oe | output | 1 | Port B output enable; 0 means high impedance |
| data_clk | output | 1 | Forwarded latch clock for the output ports |

## Verification
The bench builds the block with an 8-bit pixel word and the default latency of 7. This keeps the pipeline short compared with the test sections, so every port value can be predicted cycle by cycle. A sweep walks all 64 six-bit valid/gap patterns behind a sync leading edge, switching between single- and dual-port lines. This covers pairs split by gaps, odd-length lines that leave an A pixel waiting when the next edge comes, and mode changes on both sides of an edge.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

    // Which half of a pair the next valid pixel fills in dual-port mode.
    typedef enum logic {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } slot_e;

    // Control bits carried beside the two data words through the delay line.
    localparam int unsigned CTRL_BITS = 3;

endpackage

// File: rtl/pdm_steer.sv
// Front stage: finds sync leading edges, latches the port mode and forms A/B pairs.
module pdm_steer
    import pdm_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_hsync,
    input  logic             dual_req,
    output logic             o_upd,
    output logic             o_bupd,
    output logic             o_dual,
    output logic [PIX_W-1:0] o_a,
    output logic [PIX_W-1:0] o_b
);

    typedef struct packed {
        slot_e            slot;
        logic             dual;
        logic             hs_last;
        logic [PIX_W-1:0] hold;
        logic             upd;
        logic             bupd;
        logic [PIX_W-1:0] a;
        logic [PIX_W-1:0] b;
    } steer_t;

    steer_t st_d, st_q;
    logic   lead;
    logic   mode;

    always_comb begin
        st_d      = st_q;
        st_d.upd  = 1'b0;
        st_d.bupd = 1'b0;
        lead      = in_valid && in_hsync && !st_q.hs_last;
        mode      = lead ? dual_req : st_q.dual;
        if (in_valid) begin
            st_d.hs_last = in_hsync;
            st_d.dual    = mode;
            if (!mode) begin
                // single-port: every pixel is its own update
                st_d.upd  = 1'b1;
                st_d.a    = in_data;
                st_d.slot = SLOT_A;
            end else if (lead || st_q.slot == SLOT_A) begin
                // start a pair; a waiting A is overwritten at a leading edge
                st_d.hold = in_data;
                st_d.slot = SLOT_B;
            end else begin
                st_d.upd  = 1'b1;
                st_d.bupd = 1'b1;
                st_d.a    = st_q.hold;
                st_d.b    = in_data;
                st_d.slot = SLOT_A;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_upd  = st_q.upd;
    assign o_bupd = st_q.bupd;
    assign o_dual = st_q.dual;
    assign o_a    = st_q.a;
    assign o_b    = st_q.b;

endmodule

// File: rtl/pdm_delay.sv
// Fixed-length register line that carries the steering result toward the ports.
module pdm_delay #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_line
            logic [WIDTH-1:0] line_d [DEPTH];
            logic [WIDTH-1:0] line_q [DEPTH];

            always_comb begin
                line_d[0] = din;
                for (int i = 1; i < DEPTH; i++) begin
                    line_d[i] = line_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                for (int i = 0; i < DEPTH; i++) begin
                    line_q[i] <= rst ? '0 : line_d[i];
                end
            end

            assign dout = line_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/pdm_outstage.sv
// Output registers: port words, port B enable and the half-rate latch clock.
module pdm_outstage #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             i_upd,
    input  logic             i_bupd,
    input  logic             i_dual,
    input  logic [PIX_W-1:0] i_a,
    input  logic [PIX_W-1:0] i_b,
    output logic [PIX_W-1:0] o_a,
    output logic [PIX_W-1:0] o_b,
    output logic             o_oe,
    output logic             o_dclk
);

    typedef struct packed {
        logic [PIX_W-1:0] a;
        logic [PIX_W-1:0] b;
        logic             oe;
        logic             dclk;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (i_upd) begin
            out_d.a = i_a;
        end
        if (i_bupd) begin
            out_d.b = i_b;
        end
        out_d.oe   = i_dual;
        // low for the cycle of a data change, high the cycle after
        out_d.dclk = !i_upd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '{a: '0, b: '0, oe: 1'b0, dclk: 1'b1};
        end else begin
            out_q <= out_d;
        end
    end

    assign o_a    = out_q.a;
    assign o_b    = out_q.b;
    assign o_oe   = out_q.oe;
    assign o_dclk = out_q.dclk;

endmodule

// File: rtl/pix_demux.sv
module pix_demux
    import pdm_pkg::*;
#(
    parameter int PIX_W   = 24,
    parameter int LATENCY = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             hsync,
    input  logic             dual_req,
    output logic [PIX_W-1:0] port_a,
    output logic [PIX_W-1:0] port_b,
    output logic             port_b_oe,
    output logic             data_clk
);

    // steering register and output register take two of the LATENCY edges
    localparam int DLY    = (LATENCY > 2) ? LATENCY - 2 : 0;
    localparam int LANE_W = int'(CTRL_BITS) + 2 * PIX_W;

    logic             s_upd, s_bupd, s_dual;
    logic [PIX_W-1:0] s_a, s_b;
    logic             d_upd, d_bupd, d_dual;
    logic [PIX_W-1:0] d_a, d_b;
    logic [LANE_W-1:0] lane_in, lane_out;
    logic             dclk_half;

    pdm_steer #(.PIX_W(PIX_W)) u_steer (
        .clk      (clk),
        .rst      (rst),
        .in_valid (pix_valid),
        .in_data  (pix_data),
        .in_hsync (hsync),
        .dual_req (dual_req),
        .o_upd    (s_upd),
        .o_bupd   (s_bupd),
        .o_dual   (s_dual),
        .o_a      (s_a),
        .o_b      (s_b)
    );

    assign lane_in = {s_upd, s_bupd, s_dual, s_a, s_b};

    pdm_delay #(.WIDTH(LANE_W), .DEPTH(DLY)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .din  (lane_in),
        .dout (lane_out)
    );

    assign {d_upd, d_bupd, d_dual, d_a, d_b} = lane_out;

    pdm_outstage #(.PIX_W(PIX_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .i_upd  (d_upd),
        .i_bupd (d_bupd),
        .i_dual (d_dual),
        .i_a    (d_a),
        .i_b    (d_b),
        .o_a    (port_a),
        .o_b    (port_b),
        .o_oe   (port_b_oe),
        .o_dclk (dclk_half)
    );

    // full rate: inverted pixel clock rises mid-way between port A changes
    assign data_clk = port_b_oe ? dclk_half : ~clk;

endmodule

// File: rtl/pdm_chk.sv
module pdm_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] port_a,
    input logic [W-1:0] port_b,
    input logic         port_b_oe,
    input logic         data_clk
);

    logic rst_prev_q;

    always_ff @(posedge clk) begin
        rst_prev_q <= rst;
        if (rst_prev_q) begin
            // R9
            reset_clear_chk: assert (port_a == '0 && port_b == '0 && !port_b_oe)
                else $error("ports not cleared after reset");
        end
    end

    // R3
    b_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !port_b_oe |-> $stable(port_b));

    // R4
    pair_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        (port_b_oe && !$stable({port_a, port_b})) |-> !data_clk);

    // R4
    clk_rise_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (port_b_oe && $rose(data_clk)) |-> ($stable(port_a) && $stable(port_b)));

    // R2
    pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (port_b_oe && $past(port_b_oe) && !$stable(port_b)) |=> $stable(port_b));

endmodule

bind pix_demux pdm_chk #(.W(PIX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .port_a    (port_a),
    .port_b    (port_b),
    .port_b_oe (port_b_oe),
    .data_clk  (data_clk)
);

// File: tb/sim_pix_demux.sv
module sim_pix_demux;

    localparam int CLK_P = 10;
    localparam int W     = 8;
    localparam int LAT   = 7;
    localparam int RS    = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         pix_valid;
    logic [W-1:0] pix_data;
    logic         hsync;
    logic         dual_req;
    logic [W-1:0] port_a;
    logic [W-1:0] port_b;
    logic         port_b_oe;
    logic         data_clk;

    always #(CLK_P/2) clk = ~clk;

    pix_demux #(.PIX_W(W), .LATENCY(LAT)) u0 (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .hsync     (hsync),
        .dual_req  (dual_req),
        .port_a    (port_a),
        .port_b    (port_b),
        .port_b_oe (port_b_oe),
        .data_clk  (data_clk)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_tag = "R9";
    bit    done = 0;

    // scheduled port events, one slot per clock edge
    bit         r_rf [RS];
    bit         r_up [RS];
    bit         r_bu [RS];
    bit         r_md [RS];
    logic [W-1:0] r_a [RS];
    logic [W-1:0] r_b [RS];

    bit           m_ph, m_dual, m_hs;
    logic [W-1:0] m_hold;
    int           edge_n = 0;

    logic [W-1:0] ea, eb;
    bit           eoe, edk;

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at edge %0d: actual %0h expected %0h", tag, what, edge_n - 1, act, exp);
        end
    endtask

    task automatic model_edge(bit r, bit v, logic [W-1:0] d, bit h, bit q);
        int k = edge_n;
        int s = (k + LAT - 1) % RS;
        if (r) begin
            for (int i = 0; i < RS; i++) begin
                r_rf[i] = 0; r_up[i] = 0; r_bu[i] = 0; r_md[i] = 0;
            end
            r_rf[k % RS] = 1;
            m_ph = 0; m_dual = 0; m_hs = 0; m_hold = '0;
        end else begin
            bit lead = v && h && !m_hs;
            r_rf[s] = 0; r_up[s] = 0; r_bu[s] = 0;
            if (v) begin
                m_hs = h;
                if (lead) m_dual = q;
                if (!m_dual) begin
                    r_up[s] = 1; r_a[s] = d; m_ph = 0;
                end else if (lead || !m_ph) begin
                    m_hold = d; m_ph = 1;
                end else begin
                    r_up[s] = 1; r_bu[s] = 1; r_a[s] = m_hold; r_b[s] = d; m_ph = 0;
                end
            end
            r_md[s] = m_dual;
        end
        edge_n++;
    endtask

    task automatic observe();
        int e = (edge_n - 1) % RS;
        if (r_rf[e]) begin
            ea = '0; eb = '0; eoe = 0; edk = 1;
        end else begin
            if (r_up[e]) ea = r_a[e];
            if (r_bu[e]) eb = r_b[e];
            eoe = r_md[e];
            edk = !r_up[e];
        end
        chk(cur_tag, "port_a", port_a, ea);
        if (eoe) chk(cur_tag, "port_b", port_b, eb);
        chk("R3", "port_b_oe", W'(port_b_oe), W'(eoe));
        // clk is low here, so the full-rate clock reads 1
        chk("R4", "data_clk", W'(data_clk), W'(eoe ? edk : 1'b1));
    endtask

    task automatic step(bit r, bit v, logic [W-1:0] d, bit h, bit q);
        @(negedge clk);
        #1;
        observe();
        rst = r; pix_valid = v; pix_data = d; hsync = h; dual_req = q;
        model_edge(r, v, d, h, q);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL R5 watchdog: actual still running, expected finished");
        finish_run();
    end

    initial begin
        rst = 1; pix_valid = 0; pix_data = '0; hsync = 0; dual_req = 0;
        model_edge(1, 0, '0, 0, 0);

        // R9: reset state
        cur_tag = "R9";
        for (int i = 0; i < 4; i++) step(1, 0, '0, 0, 0);
        idle(8);

        // R3: single-port line with some gaps
        cur_tag = "R3";
        step(0, 1, 8'h01, 1, 0);
        for (int i = 0; i < 15; i++) step(0, (i % 4) != 3, 8'h10 + 8'(i), i < 3, 0);
        idle(8);

        // R7: dual request without a leading edge stays single
        cur_tag = "R7";
        for (int i = 0; i < 10; i++) step(0, 1, 8'h30 + 8'(i), 0, 1);
        idle(8);

        // R1: leading edge with dual request starts the pair on port A
        cur_tag = "R1";
        step(0, 1, 8'hA0, 1, 1);
        step(0, 1, 8'hA1, 1, 0);
        idle(8);

        // R2: contiguous dual-port stream
        cur_tag = "R2";
        for (int i = 0; i < 20; i++) step(0, 1, 8'h40 + 8'(i), 0, 0);
        idle(8);

        // R8: invalid cycles inside pairs take no slot
        cur_tag = "R8";
        for (int i = 0; i < 18; i++) step(0, (i % 3) != 1, 8'h60 + 8'(i), 0, 1);
        idle(8);

        // R6: leading edge while B is expected drops the waiting A
        cur_tag = "R6";
        step(0, 1, 8'hC0, 1, 1);
        step(0, 1, 8'hC1, 0, 0);
        step(0, 1, 8'hC2, 0, 0);
        step(0, 1, 8'hC3, 1, 1);
        step(0, 1, 8'hC4, 0, 0);
        idle(8);

        // R5: isolated single-port pixels, exact arrival edge
        cur_tag = "R5";
        step(0, 1, 8'h80, 1, 0);
        for (int i = 0; i < 4; i++) begin
            idle(8);
            step(0, 1, 8'h81 + 8'(i), 0, 0);
        end
        idle(8);

        // R2: sweep of all six-bit valid patterns behind a leading edge
        cur_tag = "R2";
        for (int p = 0; p < 64; p++) begin
            step(0, 1, 8'(p * 5), 1, (p % 4) != 0);
            for (int i = 0; i < 11; i++)
                step(0, p[i % 6], 8'(p * 7 + i * 3 + 1), i < 2, 0);
            step(0, 0, '0, 0, 0);
        end
        idle(8);

        // R9: reset in the middle of a dual-port stream
        cur_tag = "R9";
        step(0, 1, 8'hE0, 1, 1);
        for (int i = 0; i < 5; i++) step(0, 1, 8'hE1 + 8'(i), 0, 0);
        for (int i = 0; i < 3; i++) step(1, 1, 8'hEE, 0, 1);
        cur_tag = "R3";
        for (int i = 0; i < 10; i++) step(0, 1, 8'hF0 + 8'(i), 0, 1);
        idle(9);

        finish_run();
    end

endmodule